// File: doc/BRIEF.md
# Random-Access Scan State Array

This block holds a bank of state flip-flops that sit between the inputs and outputs of surrounding combinational logic. In functional mode every bit loads its parallel input on each rising edge of the functional clock, and the bit outputs drive the parallel output with no intervening stage. In scan mode the same bits behave like a one-bit-wide RAM. A single bit is chosen by an address held in a short serial shift register that has its own address clock. That bit alone takes the serial data input on the functional clock, and its stored value is always visible on the serial output.

A test controller first shifts an address in, one bit per address-clock edge and most significant bit first. A decoder turns the address into a one-hot select. Raising the test-mode input then allows the selected bit to be written, or simply read through the serial output, without disturbing any other bit. Addresses that name no existing bit select nothing. Both clock domains share one asynchronous active-low reset, and each domain releases it synchronously to its own clock.

Top module: `ras_state_array`

## Requirements
- R1: While reset is low, and after it is released, every state bit and every address bit is 0, so that `func_q` is all zeros and `scan_out` is 0.
- R2: With `test_mode` = 0, each rising edge of `clk_ck` loads `func_d` into the state bits. `func_q` shows the state bits directly, so the new value is present before the next edge.
- R3: The address register is AW = ceil(log2(NFF)) bits wide. Each rising edge of `clk_ack` shifts `addr_si` into bit 0 and moves the older bits one place toward the MSB, so after AW edges the bit sent first is the MSB. Edges of `clk_ck` and changes of `test_mode` leave the address unchanged.
- R4: When the address is below NFF, the decoder drives exactly one select line, the one whose index equals the address.
- R5: With `test_mode` = 1, a rising edge of `clk_ck` stores `scan_in` into the selected state bit.
- R6: `scan_out` equals the value of the state bit selected by the current address. It follows any new address or any write without waiting for a further edge.
- R7: With `test_mode` = 1, the state bits that are not selected keep their values across `clk_ck` edges, whatever `func_d` carries.
- R8: An address at or above NFF selects no bit. A scan-mode `clk_ck` edge then changes no state bit, and `scan_out` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ck | input | 1 | Functional clock for the state bits |
| clk_ack | input | 1 | Address clock for the serial address register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each clock domain |
| test_mode | input | 1 | 0 = functional parallel load, 1 = addressed single-bit access |
| func_d | input | NFF | Parallel next-state input from the surrounding logic |
| func_q | output | NFF | Parallel state output to the surrounding logic |
| addr_si | input | 1 | Serial address input, sent MSB first |
| scan_in | input | 1 | Serial data written into the selected bit in scan mode |
| scan_out | output | 1 | Value of the selected bit, 0 when the address is out of range |

## Verification
A functional load appears on `func_q` one `clk_ck` edge after `func_d` is applied, so the bench drives on a falling edge and samples on the next falling edge. An address takes AW `clk_ack` pulses, and the bench places each pulse inside the low half of a functional cycle. Because `scan_out` is combinational from the address and the state, the bench reads it a few nanoseconds after the last address pulse and before the next `clk_ck` rise. A scan write is due on the first `clk_ck` rise with `test_mode` high. The bench then checks the whole `func_q` word and `scan_out` at the following falling edge, so any stray change to an unselected bit is also caught.

// File: rtl/ras_pkg.sv
package ras_pkg;

  typedef enum logic {
    MODE_FUNC = 1'b0,
    MODE_SCAN = 1'b1
  } ras_mode_e;

  // Width of an index able to name n bits (at least one bit).
  function automatic int addr_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/ras_rst_sync.sv
module ras_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/ras_addr_sreg.sv
module ras_addr_sreg #(
  parameter int AW = 3
) (
  input  logic          clk_ack,
  input  logic          rst_n,
  input  logic          ser_in,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_d;

  generate
    if (AW == 1) begin : g_single
      always_comb begin
        addr_d = ser_in;
      end
    end else begin : g_multi
      always_comb begin
        addr_d = {addr_q[AW-2:0], ser_in};
      end
    end
  endgenerate

  always_ff @(posedge clk_ack or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else begin
      addr_q <= addr_d;
    end
  end

  assign addr = addr_q;

endmodule

// File: rtl/ras_addr_dec.sv
module ras_addr_dec #(
  parameter int NFF = 6,
  parameter int AW  = 3
) (
  input  logic [AW-1:0]  addr,
  output logic [NFF-1:0] sel
);

  // Indices at or above NFF have no output line, so they decode to none.
  generate
    for (genvar i = 0; i < NFF; i++) begin : g_line
      localparam logic [AW-1:0] IDX = AW'(i);
      assign sel[i] = (addr == IDX);
    end
  endgenerate

endmodule

// File: rtl/ras_cell_bank.sv
module ras_cell_bank
  import ras_pkg::*;
#(
  parameter int NFF = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  ras_mode_e      mode,
  input  logic [NFF-1:0] sel,
  input  logic [NFF-1:0] func_d,
  input  logic           scan_in,
  output logic [NFF-1:0] q,
  output logic           scan_out
);

  logic [NFF-1:0] cell_en;
  logic [NFF-1:0] cell_d;
  logic [NFF-1:0] cell_q;

  generate
    for (genvar i = 0; i < NFF; i++) begin : g_cell
      always_comb begin
        if (mode == MODE_SCAN) begin
          cell_en[i] = sel[i];
          cell_d[i]  = scan_in;
        end else begin
          cell_en[i] = 1'b1;
          cell_d[i]  = func_d[i];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cell_q[i] <= 1'b0;
        end else if (cell_en[i]) begin
          cell_q[i] <= cell_d[i];
        end
      end
    end
  endgenerate

  assign q        = cell_q;
  assign scan_out = |(cell_q & sel);

endmodule

// File: rtl/ras_state_array.sv
module ras_state_array
  import ras_pkg::*;
#(
  parameter int NFF = 6
) (
  input  logic           clk_ck,
  input  logic           clk_ack,
  input  logic           rst_n,
  input  logic           test_mode,
  input  logic [NFF-1:0] func_d,
  output logic [NFF-1:0] func_q,
  input  logic           addr_si,
  input  logic           scan_in,
  output logic           scan_out
);

  localparam int AW = addr_bits(NFF);

  logic           rst_ck_n;
  logic           rst_ack_n;
  logic [AW-1:0]  addr;
  logic [NFF-1:0] sel;
  ras_mode_e      mode;

  assign mode = ras_mode_e'(test_mode);

  ras_rst_sync u_rst_ck (
    .clk    (clk_ck),
    .arst_n (rst_n),
    .srst_n (rst_ck_n)
  );

  ras_rst_sync u_rst_ack (
    .clk    (clk_ack),
    .arst_n (rst_n),
    .srst_n (rst_ack_n)
  );

  ras_addr_sreg #(.AW(AW)) u_asr (
    .clk_ack (clk_ack),
    .rst_n   (rst_ack_n),
    .ser_in  (addr_si),
    .addr    (addr)
  );

  ras_addr_dec #(.NFF(NFF), .AW(AW)) u_dec (
    .addr (addr),
    .sel  (sel)
  );

  ras_cell_bank #(.NFF(NFF)) u_bank (
    .clk      (clk_ck),
    .rst_n    (rst_ck_n),
    .mode     (mode),
    .sel      (sel),
    .func_d   (func_d),
    .scan_in  (scan_in),
    .q        (func_q),
    .scan_out (scan_out)
  );

endmodule

// File: rtl/ras_state_array_chk.sv
module ras_state_array_chk #(
  parameter int NFF = 6,
  parameter int AW  = 3
) (
  input logic           clk_ck,
  input logic           rst_ck_n,
  input logic           test_mode,
  input logic [NFF-1:0] func_d,
  input logic [NFF-1:0] func_q,
  input logic           scan_in,
  input logic [NFF-1:0] sel,
  input logic [AW-1:0]  addr,
  input logic           scan_out
);

  // R2: functional mode loads the parallel input on the next edge
  p_func_load_r2: assert property (@(posedge clk_ck) disable iff (!rst_ck_n)
    !test_mode |=> func_q == $past(func_d));

  // R4: at most one select line is active
  p_sel_onehot_r4: assert property (@(posedge clk_ck) disable iff (!rst_ck_n)
    $onehot0(sel));

  // R4: an in-range address drives the line with its own index
  p_sel_match_r4: assert property (@(posedge clk_ck) disable iff (!rst_ck_n)
    (int'(addr) < NFF) |-> sel == (NFF'(1) << addr));

  // R5: the selected bit takes the serial data
  p_scan_write_r5: assert property (@(posedge clk_ck) disable iff (!rst_ck_n)
    test_mode |=> (func_q & $past(sel)) == ($past(scan_in) ? $past(sel) : '0));

  // R7: unselected bits hold in scan mode
  p_unsel_hold_r7: assert property (@(posedge clk_ck) disable iff (!rst_ck_n)
    test_mode |=> ((func_q ^ $past(func_q)) & ~$past(sel)) == '0);

  // R8: an out-of-range address selects nothing and reads 0
  p_oob_quiet_r8: assert property (@(posedge clk_ck) disable iff (!rst_ck_n)
    (int'(addr) >= NFF) |-> (sel == '0 && !scan_out));

endmodule

bind ras_state_array ras_state_array_chk #(.NFF(NFF), .AW(AW)) u_chk (
  .clk_ck    (clk_ck),
  .rst_ck_n  (rst_ck_n),
  .test_mode (test_mode),
  .func_d    (func_d),
  .func_q    (func_q),
  .scan_in   (scan_in),
  .sel       (sel),
  .addr      (addr),
  .scan_out  (scan_out)
);

// File: tb/sim_ras_state_array.sv
`timescale 1ns/1ps
module sim_ras_state_array;

  localparam int NFF  = 6;
  localparam int AW   = 3;
  localparam int NADR = 1 << AW;

  logic           clk_ck = 1'b0;
  logic           clk_ack = 1'b0;
  logic           rst_n = 1'b0;
  logic           test_mode = 1'b0;
  logic [NFF-1:0] func_d = '0;
  logic [NFF-1:0] func_q;
  logic           addr_si = 1'b0;
  logic           scan_in = 1'b0;
  logic           scan_out;

  logic [NFF-1:0] model;
  int             n_checks = 0;
  int             n_errors = 0;

  always #4 clk_ck = ~clk_ck;

  ras_state_array #(.NFF(NFF)) u0 (
    .clk_ck    (clk_ck),
    .clk_ack   (clk_ack),
    .rst_n     (rst_n),
    .test_mode (test_mode),
    .func_d    (func_d),
    .func_q    (func_q),
    .addr_si   (addr_si),
    .scan_in   (scan_in),
    .scan_out  (scan_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic ack_pulse(input logic b);
    @(negedge clk_ck);
    addr_si = b;
    #1 clk_ack = 1'b1;
    #1 clk_ack = 1'b0;
  endtask

  task automatic load_addr(input int a);
    for (int b = AW - 1; b >= 0; b--) begin
      ack_pulse(a[b]);
    end
    #1;
  endtask

  task automatic set_state(input logic [NFF-1:0] p);
    @(negedge clk_ck);
    test_mode = 1'b0;
    func_d    = p;
    @(negedge clk_ck);
    model = p;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #3;
    chk("R1 func_q in reset", 32'(func_q), 32'd0);
    chk("R1 scan_out in reset", 32'(scan_out), 32'd0);
    @(negedge clk_ck);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) ack_pulse(1'b0);
    repeat (3) @(negedge clk_ck);
    model = '0;
  endtask

  initial begin
    #(8 * 150000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    model = '0;
    #2;
    do_reset();
    chk("R1 func_q after reset", 32'(func_q), 32'd0);
    chk("R1 scan_out after reset", 32'(scan_out), 32'd0);

    // R2: every parallel pattern loads in functional mode
    for (int v = 0; v < (1 << NFF); v++) begin
      @(negedge clk_ck);
      test_mode = 1'b0;
      func_d    = NFF'(v);
      @(negedge clk_ck);
      chk("R2 functional load", 32'(func_q), 32'(v));
    end

    // R3/R4/R6/R8: one-hot state, read through every address
    for (int k = 0; k < NFF; k++) begin
      set_state(NFF'(1) << k);
      for (int a = 0; a < NADR; a++) begin
        load_addr(a);
        chk("R6 R3 read selected bit", 32'(scan_out), (a == k) ? 32'd1 : 32'd0);
      end
    end

    // R5/R7/R8: write each address with each value over a background pattern
    for (int a = 0; a < NADR; a++) begin
      for (int v = 0; v < 2; v++) begin
        logic [NFF-1:0] bg;
        bg = (v == 1) ? NFF'(6'b010010) : NFF'(6'b101101);
        set_state(bg);
        load_addr(a);
        @(negedge clk_ck);
        test_mode = 1'b1;
        scan_in   = v[0];
        func_d    = ~bg;
        @(negedge clk_ck);
        if (a < NFF) model[a] = v[0];
        test_mode = 1'b0;
        func_d    = model;
        #1;
        chk("R5 R7 R8 state after scan write", 32'(func_q), 32'(model));
        chk("R6 R8 scan_out after write", 32'(scan_out), (a < NFF) ? 32'(v) : 32'd0);
      end
    end

    // R7: several scan-mode edges, bits outside the address never move
    set_state(NFF'(6'b110011));
    load_addr(2);
    @(negedge clk_ck);
    test_mode = 1'b1;
    func_d    = '0;
    for (int c = 0; c < 4; c++) begin
      scan_in = c[0];
      @(negedge clk_ck);
      model[2] = c[0];
      chk("R7 R5 multi-edge scan", 32'(func_q), 32'(model));
    end
    test_mode = 1'b0;
    func_d    = model;

    // R3: address survives functional edges and mode changes
    set_state(NFF'(6'b011000));
    load_addr(4);
    @(negedge clk_ck);
    func_d = NFF'(6'b010000);
    repeat (5) @(negedge clk_ck);
    #1;
    chk("R3 address kept over clk_ck", 32'(scan_out), 32'd1);
    func_d = NFF'(6'b000000);
    @(negedge clk_ck);
    #1;
    chk("R3 R6 scan_out follows new state", 32'(scan_out), 32'd0);

    // R1: reset in mid-operation clears state and address
    set_state(NFF'(6'b111111));
    load_addr(5);
    chk("R6 read before reset", 32'(scan_out), 32'd1);
    func_d = '1;
    do_reset();
    func_d = '0;
    @(negedge clk_ck);
    chk("R1 state after second reset", 32'(func_q), 32'd0);
    set_state(NFF'(6'b000001));
    #1;
    chk("R1 address back to 0", 32'(scan_out), 32'd1);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule